// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit device virtual address into a physical address by reading descriptors from a two-level translation table in memory. A requester presents the virtual address and the base of the first-level table with a valid/ready handshake. The walker then fetches one 32-bit word per level through a simple read port. It decodes the word and either finishes or fetches the second-level word it points to.

Four mapping sizes are supported: 16 MB and 1 MB blocks described directly at the first level, and 64 KB and 4 KB pages described at the second level. Each result carries the physical address, a two-bit size code and a fault flag. The result is held until the consumer takes it. Only one translation is in flight at a time.

Top module: `ptw_walker`

## Requirements
- R1: One translation at a time: `req_ready` is low from the accepting edge until the result has been accepted, and `req_ready` and `rsp_valid` are never high together.
- R2: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_pa`, `rsp_size` and `rsp_fault` stay unchanged.
- R3: The first read goes to table base plus 4 × virtual address bits [31:20].
- R4: A first-level word with bits [1:0] = 01 is a pointer. The second read goes to that word with bits [9:0] cleared, plus 4 × virtual address bits [19:12].
- R5: A first-level word with bits [1:0] = 10 and bit 18 = 0 maps 1 MB. The result is word bits [31:20] above virtual address bits [19:0], with size code 1.
- R6: A first-level word with bits [1:0] = 10 and bit 18 = 1 maps 16 MB. The result is word bits [31:24] above virtual address bits [23:0], with size code 0.
- R7: A second-level word with bit 1 set maps 4 KB whatever bit 0 holds. The result is word bits [31:12] above virtual address bits [11:0], with size code 3.
- R8: A second-level word with bits [1:0] = 01 maps 64 KB. The result is word bits [31:16] above virtual address bits [15:0], with size code 2.
- R9: A first-level word with bits [1:0] of 00 or 11, or a second-level word with bits [1:0] of 00, completes the request with `rsp_fault` = 1, `rsp_pa` = 0 and `rsp_size` = 0. A first-level fault issues no second read.
- R10: While `mem_rd_valid` is high and `mem_rd_ready` is low, `mem_rd_valid` and `mem_rd_addr` stay unchanged.
- R11: After reset, `req_ready` = 1, `rsp_valid` = 0 and `mem_rd_valid` = 0.
- R12: The table base is taken at acceptance. Changing `tbl_base` during a walk has no effect on that walk's reads or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base | input | 32 | First-level table base, sampled at acceptance |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_pa | output | 32 | Translated physical address (0 on fault) |
| rsp_size | output | 2 | 0 = 16 MB, 1 = 1 MB, 2 = 64 KB, 3 = 4 KB |
| rsp_fault | output | 1 | Translation fault |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Descriptor word address |
| mem_rd_data_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Descriptor word |

## Verification
The bench builds the walker with its default geometry: 32-bit addresses, 12 first-level index bits, 8 second-level index bits, and the 16 MB / 1 MB / 64 KB / 4 KB shifts. This places every size boundary and both index fields at the bit positions the requirements name. With these values, hand-built descriptors can be written into a sparse memory model at computed entry addresses. Junk bits between the size mask and the type bits check that only the masked bits reach the result. A stalling memory-ready pattern keeps read requests waiting, which tests the address-hold and base-sampling rules.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [1:0] {
      DK_FAULT = 2'd0,
      DK_TABLE = 2'd1,
      DK_LEAF  = 2'd2
   } desc_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_L1_REQ  = 3'd1,
      ST_L1_WAIT = 3'd2,
      ST_L2_REQ  = 3'd3,
      ST_L2_WAIT = 3'd4,
      ST_DONE    = 3'd5
   } walk_state_e;

   localparam logic [1:0] SZ_16M  = 2'd0;
   localparam logic [1:0] SZ_1M   = 2'd1;
   localparam logic [1:0] SZ_64K  = 2'd2;
   localparam logic [1:0] SZ_4K   = 2'd3;
   localparam int         NUM_GRAN = 4;

endpackage

// File: rtl/ptw_merge.sv
// Joins descriptor bits above SHIFT with virtual-address bits below it.
module ptw_merge #(
   parameter int W     = 32,
   parameter int SHIFT = 20
) (
   input  logic [W-1:0] desc,
   input  logic [W-1:0] va,
   output logic [W-1:0] pa
);
   localparam logic [W-1:0] HI_MASK = {{(W-SHIFT){1'b1}}, {SHIFT{1'b0}}};

   assign pa = (desc & HI_MASK) | (va & ~HI_MASK);
endmodule

// File: rtl/ptw_desc_decode.sv
// Classifies a descriptor word for either table level.
module ptw_desc_decode
   import ptw_pkg::*;
#(
   parameter int W         = 32,
   parameter int SUPER_BIT = 18
) (
   input  logic [W-1:0] desc,
   input  logic         level2,
   output desc_kind_e   kind,
   output logic [1:0]   size
);
   always_comb begin
      kind = DK_FAULT;
      size = SZ_16M;
      if (level2) begin
         if (desc[1]) begin
            kind = DK_LEAF;
            size = SZ_4K;
         end else if (desc[0]) begin
            kind = DK_LEAF;
            size = SZ_64K;
         end
      end else begin
         unique case (desc[1:0])
            2'b01: kind = DK_TABLE;
            2'b10: begin
               kind = DK_LEAF;
               size = desc[SUPER_BIT] ? SZ_16M : SZ_1M;
            end
            default: kind = DK_FAULT;
         endcase
      end
   end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int L1_SHIFT    = 20,
   parameter int L2_SHIFT    = 12,
   parameter int SUPER_SHIFT = 24,
   parameter int LARGE_SHIFT = 16,
   parameter int L2_ALIGN    = 10,
   parameter int SUPER_BIT   = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       tbl_base,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [31:0]       req_va,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [31:0]       rsp_pa,
   output logic [1:0]        rsp_size,
   output logic              rsp_fault,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [31:0]       mem_rd_addr,
   input  logic              mem_rd_data_valid,
   input  logic [31:0]       mem_rd_data
);
   localparam int L1_IDX_W = ADDR_W - L1_SHIFT;
   localparam int L2_IDX_W = L1_SHIFT - L2_SHIFT;
   localparam int WORD_SH  = 2;
   localparam int GRAN_SHIFT [NUM_GRAN] = '{SUPER_SHIFT, L1_SHIFT, LARGE_SHIFT, L2_SHIFT};

   initial begin
      if (ADDR_W != 32)
         $fatal(1, "ptw_walker: ADDR_W must match the 32-bit ports");
      if (!(L2_SHIFT < LARGE_SHIFT && LARGE_SHIFT < L1_SHIFT &&
            L1_SHIFT < SUPER_SHIFT && SUPER_SHIFT < ADDR_W))
         $fatal(1, "ptw_walker: granularity shifts must strictly increase");
      if (L2_ALIGN < L2_IDX_W + WORD_SH)
         $fatal(1, "ptw_walker: second-level alignment too small for its index");
      if (SUPER_BIT < 2 || SUPER_BIT >= L1_SHIFT)
         $fatal(1, "ptw_walker: attribute bit must lie in the descriptor offset field");
   end

   walk_state_e       state_q;
   logic [ADDR_W-1:0] va_q, base_q, l2_base_q, pa_q;
   logic [1:0]        size_q;
   logic              fault_q;

   desc_kind_e        dec_kind;
   logic [1:0]        dec_size;
   logic [ADDR_W-1:0] merged [NUM_GRAN];
   logic [ADDR_W-1:0] l1_addr, l2_addr;

   ptw_desc_decode #(.W(ADDR_W), .SUPER_BIT(SUPER_BIT)) u_decode (
      .desc   (mem_rd_data),
      .level2 (state_q == ST_L2_WAIT),
      .kind   (dec_kind),
      .size   (dec_size)
   );

   for (genvar g = 0; g < NUM_GRAN; g++) begin : g_gran
      ptw_merge #(.W(ADDR_W), .SHIFT(GRAN_SHIFT[g])) u_merge (
         .desc (mem_rd_data),
         .va   (va_q),
         .pa   (merged[g])
      );
   end

   assign l1_addr = base_q +
                    ADDR_W'({va_q[ADDR_W-1 -: L1_IDX_W], {WORD_SH{1'b0}}});
   assign l2_addr = l2_base_q +
                    ADDR_W'({va_q[L1_SHIFT-1 -: L2_IDX_W], {WORD_SH{1'b0}}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         va_q      <= '0;
         base_q    <= '0;
         l2_base_q <= '0;
         pa_q      <= '0;
         size_q    <= SZ_16M;
         fault_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               va_q    <= req_va;
               base_q  <= tbl_base;
               state_q <= ST_L1_REQ;
            end
            ST_L1_REQ: if (mem_rd_ready) state_q <= ST_L1_WAIT;
            ST_L2_REQ: if (mem_rd_ready) state_q <= ST_L2_WAIT;
            ST_L1_WAIT, ST_L2_WAIT: if (mem_rd_data_valid) begin
               if (dec_kind == DK_TABLE && state_q == ST_L1_WAIT) begin
                  l2_base_q <= {mem_rd_data[ADDR_W-1:L2_ALIGN], {L2_ALIGN{1'b0}}};
                  state_q   <= ST_L2_REQ;
               end else if (dec_kind == DK_LEAF) begin
                  pa_q    <= merged[dec_size];
                  size_q  <= dec_size;
                  fault_q <= 1'b0;
                  state_q <= ST_DONE;
               end else begin
                  pa_q    <= '0;
                  size_q  <= SZ_16M;
                  fault_q <= 1'b1;
                  state_q <= ST_DONE;
               end
            end
            ST_DONE: if (rsp_ready) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready    = (state_q == ST_IDLE);
   assign mem_rd_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
   assign mem_rd_addr  = (state_q == ST_L2_REQ) ? l2_addr : l1_addr;
   assign rsp_valid    = (state_q == ST_DONE);
   assign rsp_pa       = pa_q;
   assign rsp_size     = size_q;
   assign rsp_fault    = fault_q;

   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ready && rsp_valid)) else $error("busy overlap"); // R1

   AST_NO_READ_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !mem_rd_valid) else $error("read while result shown"); // R1

   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) &&
      $stable(rsp_size) && $stable(rsp_fault)) else $error("result moved"); // R2

   AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr))
      else $error("read request moved"); // R10

   AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> rsp_pa == '0 && rsp_size == SZ_16M)
      else $error("fault carries an address"); // R9

endmodule

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] tbl_base = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [31:0] rsp_pa;
   logic [1:0]  rsp_size;
   logic        rsp_fault;
   logic        mem_rd_valid;
   logic        mem_rd_ready;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_data_valid = 1'b0;
   logic [31:0] mem_rd_data = '0;

   int checks = 0;
   int errors = 0;
   logic stall_mode = 1'b0;
   logic [31:0] cyc = '0;
   int nlog = 0;
   logic [31:0] rd_log [0:255];
   logic [31:0] mem_img [logic [31:0]];

   logic [31:0] got_pa, got_l1, got_l2;
   logic [1:0]  got_size;
   logic        got_fault;
   int          got_reads;

   localparam logic [31:0] BASE_A = 32'h8000_0000;
   localparam logic [31:0] BASE_B = 32'h2000_0000;
   localparam logic [31:0] L2TAB  = 32'h4000_0400;

   always #10 clk = ~clk;

   ptw_walker uut (
      .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
      .rsp_size(rsp_size), .rsp_fault(rsp_fault),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
      .mem_rd_addr(mem_rd_addr), .mem_rd_data_valid(mem_rd_data_valid),
      .mem_rd_data(mem_rd_data)
   );

   assign mem_rd_ready = !stall_mode || (cyc[1:0] == 2'd3);

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return mem_img.exists(a) ? mem_img[a] : 32'h0;
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      mem_rd_data_valid <= 1'b0;
      if (mem_rd_valid && mem_rd_ready) begin
         mem_rd_data_valid <= 1'b1;
         mem_rd_data <= mem_word(mem_rd_addr);
         rd_log[nlog[7:0]] <= mem_rd_addr;
         nlog <= nlog + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xlate(input logic [31:0] base, input logic [31:0] va,
                        input logic [31:0] alt_base, input int hold);
      int start;
      int wait_cnt;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      start = nlog;
      tbl_base  = base;
      req_va    = va;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      tbl_base  = alt_base;
      chk(req_ready == 1'b0, "R1 busy after accept", {31'b0, req_ready}, 32'h0);
      wait_cnt = 0;
      while (!rsp_valid && wait_cnt < 200) begin
         chk(req_ready == 1'b0, "R1 busy during walk", {31'b0, req_ready}, 32'h0);
         @(negedge clk);
         wait_cnt++;
      end
      got_pa    = rsp_pa;
      got_size  = rsp_size;
      got_fault = rsp_fault;
      got_reads = nlog - start;
      got_l1    = rd_log[start[7:0]];
      got_l2    = rd_log[8'(start + 1)];
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         chk(rsp_valid && rsp_pa == got_pa && rsp_size == got_size &&
             rsp_fault == got_fault, "R2 result held", rsp_pa, got_pa);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(!rsp_valid && req_ready, "R1 ready after accept",
          {30'b0, rsp_valid, req_ready}, 32'h1);
   endtask

   task automatic t_reset;
      chk(req_ready == 1'b1, "R11 req_ready", {31'b0, req_ready}, 32'h1);
      chk(rsp_valid == 1'b0, "R11 rsp_valid", {31'b0, rsp_valid}, 32'h0);
      chk(mem_rd_valid == 1'b0, "R11 mem_rd_valid", {31'b0, mem_rd_valid}, 32'h0);
   endtask

   task automatic t_section;
      mem_img[BASE_A + 32'h48C] = 32'hABC0_0C02;
      xlate(BASE_A, 32'h1234_5678, BASE_A, 3);
      chk(got_l1 == BASE_A + 32'h48C, "R3 l1 address", got_l1, BASE_A + 32'h48C);
      chk(got_pa == 32'hABC4_5678, "R5 section pa", got_pa, 32'hABC4_5678);
      chk(got_size == 2'd1 && !got_fault, "R5 section size", {30'b0, got_size}, 32'h1);
      chk(got_reads == 1, "R5 single read", got_reads, 32'h1);
   endtask

   task automatic t_super;
      mem_img[BASE_A + 32'h159C] = 32'h9A04_0002;
      xlate(BASE_A, 32'h5678_9ABC, BASE_A, 0);
      chk(got_pa == 32'h9A78_9ABC, "R6 super pa", got_pa, 32'h9A78_9ABC);
      chk(got_size == 2'd0 && !got_fault, "R6 super size", {30'b0, got_size}, 32'h0);
   endtask

   task automatic t_small;
      mem_img[BASE_A + 32'h2AC] = L2TAB | 32'h1;
      mem_img[L2TAB + 32'hD0]   = 32'h7777_7002;
      mem_img[L2TAB + 32'hD4]   = 32'h6666_6003;
      xlate(BASE_A, 32'h0AB3_4DEF, BASE_A, 2);
      chk(got_l2 == L2TAB + 32'hD0, "R4 l2 address", got_l2, L2TAB + 32'hD0);
      chk(got_reads == 2, "R4 two reads", got_reads, 32'h2);
      chk(got_pa == 32'h7777_7DEF, "R7 small pa", got_pa, 32'h7777_7DEF);
      chk(got_size == 2'd3 && !got_fault, "R7 small size", {30'b0, got_size}, 32'h3);
      xlate(BASE_A, 32'h0AB3_5DEF, BASE_A, 0);
      chk(got_pa == 32'h6666_6DEF, "R7 small with bit0", got_pa, 32'h6666_6DEF);
      chk(got_size == 2'd3, "R7 small size bit0", {30'b0, got_size}, 32'h3);
   endtask

   task automatic t_large;
      mem_img[L2TAB + 32'h104] = 32'h5555_0001;
      xlate(BASE_A, 32'h0AB4_1234, BASE_A, 0);
      chk(got_l2 == L2TAB + 32'h104, "R4 l2 address large", got_l2, L2TAB + 32'h104);
      chk(got_pa == 32'h5555_1234, "R8 large pa", got_pa, 32'h5555_1234);
      chk(got_size == 2'd2 && !got_fault, "R8 large size", {30'b0, got_size}, 32'h2);
   endtask

   task automatic t_faults;
      xlate(BASE_A, 32'h7000_0000, BASE_A, 1);
      chk(got_fault && got_pa == 0 && got_size == 0, "R9 l1 type 00",
          {got_fault, got_pa[30:0]}, 32'h8000_0000);
      chk(got_reads == 1, "R9 no second read", got_reads, 32'h1);
      mem_img[BASE_A + 32'h1C04] = 32'h1234_5673;
      xlate(BASE_A, 32'h7010_0000, BASE_A, 0);
      chk(got_fault && got_pa == 0, "R9 l1 type 11", {31'b0, got_fault}, 32'h1);
      chk(got_reads == 1, "R9 no second read 11", got_reads, 32'h1);
      xlate(BASE_A, 32'h0AB5_0000, BASE_A, 0);
      chk(got_fault && got_pa == 0 && got_size == 0, "R9 l2 type 00",
          {31'b0, got_fault}, 32'h1);
      chk(got_reads == 2, "R9 l2 fault reads", got_reads, 32'h2);
   endtask

   task automatic t_base_sampled;
      stall_mode = 1'b1;
      mem_img[BASE_B + 32'h4] = 32'h3330_0002;
      xlate(BASE_B, 32'h0010_0000, BASE_A, 0);
      chk(got_l1 == BASE_B + 32'h4, "R12 base sampled", got_l1, BASE_B + 32'h4);
      chk(got_pa == 32'h3330_0000, "R12 result", got_pa, 32'h3330_0000);
      xlate(BASE_A, 32'h0AB3_4DEF, BASE_B, 0);
      chk(got_l2 == L2TAB + 32'hD0, "R10 stalled l2 address", got_l2, L2TAB + 32'hD0);
      chk(got_pa == 32'h7777_7DEF, "R10 stalled result", got_pa, 32'h7777_7DEF);
      stall_mode = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_section;
      t_super;
      t_small;
      t_large;
      t_faults;
      t_base_sampled;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 50000);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule